// File: doc/BRIEF.md
# Byte-Serial AES-128 Round Sequencer

This block is the control engine of a small AES-128 encryptor that moves one byte per clock through a single shared function unit. That unit holds one arithmetic function at a time: byte substitution, column mixing or byte XOR. Before the sequencer uses a different function, it raises a request and stalls until an external loader reports completion. It does not repeat a request for the function that is already present.

After a start pulse, the sequencer reads the 16 plaintext bytes and then the 16 key bytes. It then steps through the initial key addition and ten rounds, with the round-key derivation interleaved into each round. Last, it writes the 16 result bytes out. On every cycle it presents an operation code, a source byte index, a destination byte index, the round number and the round constant. A register bank and the function unit use these outputs to move data. The arithmetic itself lives outside this block.

Top module: `aes_byte_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy`, `done` and `fn_req` are 0 and `op` is 0 (idle). Reset also forgets which function is loaded.
- R2: `start` is taken only in the idle state. A `start` raised while `busy` is high leaves the running sequence unchanged.
- R3: A run begins with 16 cycles of `op`=1 (read plaintext) and then 16 cycles of `op`=2 (read key). In both, `src_idx` and `dst_idx` count 0 to 15.
- R4: During a function wait (`op` 3, 5, 8 or 10), `fn_req` is 1 and `fn_sel` names the function: 1 substitution, 2 mixing, 3 XOR. The wait holds until `cfg_done` is sampled high and leaves on the following cycle. `fn_req` is 0 in every other state.
- R5: A wait is skipped entirely when the requested function is already loaded. A run that directly follows a finished run therefore goes from key read straight to key addition. After reset, the first run waits for XOR (`op`=3).
- R6: The initial key addition (`op`=4, 16 cycles) follows the XOR wait. Each round of 1 to 9 then does: substitution wait (5), key-word substitution (6, 4 cycles), state substitution (7, 16), mixing wait (8), mixing (9, 16), XOR wait (10), key derivation (11, 16) and key addition (4, 16).
- R7: Round 10 goes from state substitution directly to the XOR wait, with no mixing. After its key addition, 16 cycles of output write (`op`=12, index 0 to 15) follow.
- R8: In state substitution, step p reads byte p and writes it to the row-shifted position. With row r = p mod 4 and column c = p div 4, the destination is 4*((c - r) mod 4) + r.
- R9: In key-word substitution, step k (0 to 3) reads key byte 12 + ((k+1) mod 4) and writes temporary byte k.
- R10: `round` is 0 through the initial key addition and r through every state of round r. During key derivation, `rcon` is the round constant of the current round (01,02,04,08,10,20,40,80,1B,36); otherwise it is 0.
- R11: `done` is high for exactly one cycle, the cycle after the last output byte. In that cycle the block is idle with `busy` low.
- R12: The phase register is one-hot. `op` reports the active phase with the codes given above.
- R13: `cfg_done` has no effect outside a function wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one encryption (taken only when idle) |
| cfg_done | input | 1 | Function unit finished loading the requested function |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | One-cycle pulse after the last output byte |
| fn_req | output | 1 | Function change requested, waiting for `cfg_done` |
| fn_sel | output | 2 | Requested function: 1 substitution, 2 mixing, 3 XOR |
| op | output | 4 | Current phase code |
| src_idx | output | 4 | Byte index read this cycle |
| dst_idx | output | 4 | Byte index written this cycle |
| round | output | 4 | Current round, 0 to 10 |
| rcon | output | 8 | Round constant during key derivation, else 0 |

## Verification
The bench builds the block with its default values: ten rounds, a 16-byte state and a 4-byte key word. These values make the final-round branch, the full 16-step row-shift pattern and all ten round constants reachable within one run. The loader delay is drawn at random from 0 to 3 cycles, and the zero-cycle case exercises the exit directly after a request. Back-to-back runs reach the skipped XOR wait. A reset in the middle of a run restores that wait. Runs with noise inject stray `cfg_done` and `start` pulses into the working phases.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

    localparam int NPH = 13;

    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_RDS   = 4'd1,
        OP_RDK   = 4'd2,
        OP_CFGX1 = 4'd3,
        OP_ARK   = 4'd4,
        OP_CFGS  = 4'd5,
        OP_SUBW  = 4'd6,
        OP_SUBB  = 4'd7,
        OP_CFGM  = 4'd8,
        OP_MIX   = 4'd9,
        OP_CFGX2 = 4'd10,
        OP_CALC  = 4'd11,
        OP_WR    = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        FN_NONE = 2'd0,
        FN_SBOX = 2'd1,
        FN_MIX  = 2'd2,
        FN_XOR  = 2'd3
    } fn_e;

    function automatic logic [7:0] gf_dbl(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] rcon_of(input logic [3:0] r);
        logic [7:0] v;
        v = 8'h01;
        for (int i = 2; i < 16; i++) begin
            if (i <= int'(r)) v = gf_dbl(v);
        end
        return (r == 4'd0) ? 8'h00 : v;
    endfunction

    function automatic logic is_wait(input logic [3:0] o);
        return (o == OP_CFGX1) || (o == OP_CFGS) || (o == OP_CFGM) || (o == OP_CFGX2);
    endfunction

    function automatic fn_e fn_of(input logic [3:0] o);
        case (o)
            OP_CFGX1, OP_CFGX2: return FN_XOR;
            OP_CFGS:            return FN_SBOX;
            OP_CFGM:            return FN_MIX;
            default:            return FN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/seq_onehot_enc.sv
module seq_onehot_enc #(
    parameter int N = 13,
    parameter int W = 4
) (
    input  logic [N-1:0] onehot,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | W'(i);
        end
    end
endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (en)    cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/seq_addr_map.sv
module seq_addr_map
    import aes_seq_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [3:0]    op,
    input  logic [IW-1:0] step,
    output logic [IW-1:0] src,
    output logic [IW-1:0] dst
);
    localparam int CW = IW - 2;

    logic [1:0]    row;
    logic [CW-1:0] col;
    logic [CW-1:0] shcol;

    assign row   = step[1:0];
    assign col   = step[IW-1:2];
    assign shcol = col - CW'(row);

    always_comb begin
        src = '0;
        dst = '0;
        case (op)
            OP_RDS, OP_RDK, OP_ARK, OP_MIX, OP_CALC, OP_WR: begin
                src = step;
                dst = step;
            end
            OP_SUBB: begin
                src = step;
                dst = {shcol, row};
            end
            OP_SUBW: begin
                src = {{CW{1'b1}}, row + 2'd1};
                dst = step;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/aes_byte_sequencer.sv
module aes_byte_sequencer
    import aes_seq_pkg::*;
#(
    parameter int NR     = 10,
    parameter int NBYTES = 16,
    parameter int WBYTES = 4,
    localparam int IW    = $clog2(NBYTES),
    localparam int RW    = $clog2(NR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cfg_done,
    output logic          busy,
    output logic          done,
    output logic          fn_req,
    output logic [1:0]    fn_sel,
    output logic [3:0]    op,
    output logic [IW-1:0] src_idx,
    output logic [IW-1:0] dst_idx,
    output logic [RW-1:0] round,
    output logic [7:0]    rcon
);
    localparam logic [RW-1:0] LAST_RND = RW'(NR);

    logic [NPH-1:0] phase_q, phase_d;
    logic [3:0]     op_cur;
    logic [IW-1:0]  step;
    logic           step_last, step_en;
    fn_e            loaded_q;
    logic [RW-1:0]  round_q;
    logic           done_q;

    function automatic logic [NPH-1:0] oh(input op_e p);
        return NPH'(1) << p;
    endfunction

    function automatic logic [NPH-1:0] go_fn(input fn_e have, input fn_e want,
                                             input op_e wait_p, input op_e work_p);
        return (have == want) ? oh(work_p) : oh(wait_p);
    endfunction

    seq_onehot_enc #(.N(NPH), .W(4)) u_enc (
        .onehot (phase_q),
        .idx    (op_cur)
    );

    assign step_en   = (op_cur != OP_IDLE) && !is_wait(op_cur);
    assign step_last = (op_cur == OP_SUBW) ? (step == IW'(WBYTES - 1))
                                           : (step == IW'(NBYTES - 1));

    seq_step_ctr #(.W(IW)) u_step (
        .clk (clk),
        .rst (rst),
        .clr (phase_d != phase_q),
        .en  (step_en),
        .cnt (step)
    );

    seq_addr_map #(.IW(IW)) u_map (
        .op   (op_cur),
        .step (step),
        .src  (src_idx),
        .dst  (dst_idx)
    );

    always_comb begin
        phase_d = phase_q;
        case (op_cur)
            OP_IDLE:  if (start)     phase_d = oh(OP_RDS);
            OP_RDS:   if (step_last) phase_d = oh(OP_RDK);
            OP_RDK:   if (step_last) phase_d = go_fn(loaded_q, FN_XOR, OP_CFGX1, OP_ARK);
            OP_CFGX1: if (cfg_done)  phase_d = oh(OP_ARK);
            OP_ARK:   if (step_last) phase_d = (round_q == LAST_RND) ? oh(OP_WR)
                                     : go_fn(loaded_q, FN_SBOX, OP_CFGS, OP_SUBW);
            OP_CFGS:  if (cfg_done)  phase_d = oh(OP_SUBW);
            OP_SUBW:  if (step_last) phase_d = oh(OP_SUBB);
            OP_SUBB:  if (step_last) phase_d = (round_q == LAST_RND)
                                     ? go_fn(loaded_q, FN_XOR, OP_CFGX2, OP_CALC)
                                     : go_fn(loaded_q, FN_MIX, OP_CFGM, OP_MIX);
            OP_CFGM:  if (cfg_done)  phase_d = oh(OP_MIX);
            OP_MIX:   if (step_last) phase_d = go_fn(loaded_q, FN_XOR, OP_CFGX2, OP_CALC);
            OP_CFGX2: if (cfg_done)  phase_d = oh(OP_CALC);
            OP_CALC:  if (step_last) phase_d = oh(OP_ARK);
            OP_WR:    if (step_last) phase_d = oh(OP_IDLE);
            default:                 phase_d = oh(OP_IDLE);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= oh(OP_IDLE);
            loaded_q <= FN_NONE;
            round_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= (op_cur == OP_WR) && step_last;
            if (is_wait(op_cur) && cfg_done) loaded_q <= fn_of(op_cur);
            if (op_cur == OP_IDLE && start)
                round_q <= '0;
            else if (op_cur == OP_ARK && step_last && round_q != LAST_RND)
                round_q <= round_q + RW'(1);
        end
    end

    assign op     = op_cur;
    assign busy   = (op_cur != OP_IDLE);
    assign done   = done_q;
    assign fn_req = is_wait(op_cur);
    assign fn_sel = fn_of(op_cur);
    assign round  = round_q;
    assign rcon   = (op_cur == OP_CALC) ? rcon_of(4'(round_q)) : 8'h00;

    // R12
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_q) == 1);

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fn_req && !cfg_done |=> fn_req && $stable(fn_sel));

    // R4
    wait_leave_chk: assert property (@(posedge clk) disable iff (rst)
        fn_req && cfg_done |=> !fn_req);

    // R5
    skip_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fn_req) |-> fn_sel != loaded_q);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(op) == OP_WR && !busy);

    // R10
    round_range_chk: assert property (@(posedge clk) disable iff (rst)
        round <= LAST_RND);
endmodule

// File: tb/aes_byte_sequencer_bench.sv
`timescale 1ns/1ps
module aes_byte_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cfg_done = 1'b0;
    logic       busy, done, fn_req;
    logic [1:0] fn_sel;
    logic [3:0] op, src_idx, dst_idx, round;
    logic [7:0] rcon;

    int n_chk = 0;
    int n_bad = 0;

    int exp_op  [0:127];
    int exp_len [0:127];
    int exp_rnd [0:127];
    int n_exp;

    always #4 clk = ~clk;

    aes_byte_sequencer u_aes_byte_sequencer (
        .clk(clk), .rst(rst), .start(start), .cfg_done(cfg_done),
        .busy(busy), .done(done), .fn_req(fn_req), .fn_sel(fn_sel),
        .op(op), .src_idx(src_idx), .dst_idx(dst_idx),
        .round(round), .rcon(rcon)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rc_exp(input int r);
        case (r)
            1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
            5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
            9: return 8'h1b; 10: return 8'h36;
            default: return 0;
        endcase
    endfunction

    function automatic int want_fn(input int o);
        case (o)
            3, 10: return 3;
            5:     return 1;
            8:     return 2;
            default: return 0;
        endcase
    endfunction

    task automatic push(input int o, input int len, input int r);
        exp_op[n_exp]  = o;
        exp_len[n_exp] = len;
        exp_rnd[n_exp] = r;
        n_exp++;
    endtask

    // R6 R7: expected phase program of one encryption
    task automatic build_exp(input bit xor_loaded);
        n_exp = 0;
        push(1, 16, 0);
        push(2, 16, 0);
        if (!xor_loaded) push(3, 0, 0);
        push(4, 16, 0);
        for (int r = 1; r <= 10; r++) begin
            push(5, 0, r);
            push(6, 4, r);
            push(7, 16, r);
            if (r < 10) begin
                push(8, 0, r);
                push(9, 16, r);
            end
            push(10, 0, r);
            push(11, 16, r);
            push(4, 16, r);
        end
        push(12, 16, 10);
    endtask

    task automatic check_step(input int k, input int p);
        int o, es, ed, rw, cl;
        o = exp_op[k];
        es = p; ed = p;
        if (o == 7) begin
            rw = p % 4;
            cl = ((p / 4) - rw + 4) % 4;
            ed = cl * 4 + rw;
        end else if (o == 6) begin
            es = 12 + ((p + 1) % 4);
        end
        if (exp_len[k] != 0) begin
            if (o == 7) begin
                chk(src_idx == 4'(es), "R8 src", src_idx, es);
                chk(dst_idx == 4'(ed), "R8 dst", dst_idx, ed);
            end else if (o == 6) begin
                chk(src_idx == 4'(es), "R9 src", src_idx, es);
                chk(dst_idx == 4'(ed), "R9 dst", dst_idx, ed);
            end else begin
                chk(src_idx == 4'(es), "R3 src", src_idx, es);
                chk(dst_idx == 4'(ed), "R3 dst", dst_idx, ed);
            end
        end
        chk(fn_req == (want_fn(o) != 0), "R4 fn_req", fn_req, want_fn(o) != 0);
        if (want_fn(o) != 0) chk(fn_sel == 2'(want_fn(o)), "R4 fn_sel", fn_sel, want_fn(o));
        chk(round == 4'(exp_rnd[k]), "R10 round", round, exp_rnd[k]);
        chk(rcon == 8'((o == 11) ? rc_exp(exp_rnd[k]) : 0), "R10 rcon", rcon,
            (o == 11) ? rc_exp(exp_rnd[k]) : 0);
        chk(busy && !done, "R11 busy/done while running", {busy, done}, 2);
    endtask

    // one encryption, checked cycle by cycle against the expected program
    task automatic run_encrypt(input bit xor_loaded, input bit noise);
        int k, pos, dly, wcnt, cyc;
        bit drove, fin, ok_in, ok_nx;
        build_exp(xor_loaded);
        k = 0; pos = 0; wcnt = 0; dly = $urandom % 4; drove = 0; fin = 0; cyc = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 5000) begin
            cyc++;
            ok_in = (int'(op) == exp_op[k]) &&
                    ((exp_len[k] == 0) ? !drove : (pos < exp_len[k]));
            ok_nx = (k + 1 < n_exp) && (int'(op) == exp_op[k + 1]) &&
                    ((exp_len[k] == 0) ? drove : (pos == exp_len[k]));
            if (ok_in) begin
                check_step(k, pos);
                pos++;
            end else if (ok_nx) begin
                if (k == 1) chk(xor_loaded || op == 4'd3, "R5 first wait present", op, 3);
                if (k == 1) chk(!xor_loaded || op == 4'd4, "R5 wait skipped", op, 4);
                k++;
                pos = 0;
                check_step(k, pos);
                pos++;
            end else if (op == 4'd0 && k == n_exp - 1 && pos == 16) begin
                chk(done == 1'b1, "R11 done pulse", done, 1);
                chk(busy == 1'b0, "R11 idle at done", busy, 0);
                fin = 1;
            end else begin
                chk(1'b0, (noise ? "R12 R6 R7 R2 R13 phase order" : "R12 R6 R7 phase order"),
                    op, exp_op[k]);
                fin = 1;
            end
            drove = 0;
            if (fin) begin
                cfg_done = 1'b0;
                start = 1'b0;
            end else begin
                if (fn_req) begin
                    if (wcnt >= dly) begin
                        cfg_done = 1'b1; drove = 1; wcnt = 0; dly = $urandom % 4;
                    end else begin
                        cfg_done = 1'b0; wcnt++;
                    end
                end else begin
                    // R13: stray completion outside a wait
                    cfg_done = noise ? (($urandom % 3) == 0) : 1'b0;
                end
                // R2: start while busy must be ignored
                start = noise ? (($urandom % 4) == 0) : 1'b0;
                @(negedge clk);
            end
        end
        chk(fin, "R6 run completes", cyc, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11 done lasts one cycle", done, 0);
        chk(op == 4'd0, "R2 stays idle without start", op, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !done && !fn_req && op == 4'd0, "R1 in reset", {busy, done, fn_req, op}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fn_req && op == 4'd0, "R1 after reset", {busy, done, fn_req, op}, 0);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        chk(op == 4'd0, "R13 stray done in idle", op, 0);

        run_encrypt(1'b0, 1'b0);
        run_encrypt(1'b1, 1'b0);
        run_encrypt(1'b1, 1'b1);

        // reset in the middle of a run, then the XOR wait must come back
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fn_req && op == 4'd0, "R1 mid-run reset", {busy, done, fn_req, op}, 0);
        rst = 1'b0;
        @(negedge clk);
        run_encrypt(1'b0, 1'b1);
        run_encrypt(1'b1, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule